// File: doc/BRIEF.md
# Vectored Interrupt Controller with Memory-Mapped Registers

This block gathers up to 32 interrupt request lines into one interrupt output for a processor. Each line has a fixed way of being detected, chosen when the block is built: rising edge, falling edge, high level or low level. Software cannot change it. A detected request is latched into a status word. The status word is then masked by an enable word to give the pending word. A master enable gates the output.

Software reaches the block through a small register bus. The bus has eight word addresses, a write strobe, a read strobe and read data that is valid in the same cycle as the strobe. Enable bits can be set or cleared atomically through two separate write-one registers, so no read-modify-write is needed. Requests are acknowledged by writing ones to an acknowledge register. A vector register returns the number of the lowest pending line, so the handler can dispatch without scanning the pending word.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, status, enable and master enable are all zero and `irq_out` is low. The vector register reads 0xFFFFFFFF.
- R2: The word addresses are: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master enable. Acknowledge, set-enable and clear-enable read as zero. `bus_rdata` is zero while `bus_rd` is low.
- R3: A write to address 2 loads the enable word. A write to address 4 sets every enable bit that is 1 in the data. A write to address 5 clears every enable bit that is 1 in the data. All other enable bits keep their value.
- R4: A write to address 3 clears each status bit whose data bit is 1. Writing 0xFFFFFFFF acknowledges every line.
- R5: Pending is status AND enable. Writes to status, pending and vector have no effect.
- R6: An edge line sets its status bit only when its input differs from a registered copy of that input in the chosen direction. A line held at its active value does not set the bit again after an acknowledge.
- R7: A level line sets its status bit on every clock while active. If it is still active after an acknowledge, its bit is clear for one cycle and set again at the next clock.
- R8: Line n's sense sits in bits [2n+1:2n] of parameter `SENSE`: 0 rising, 1 falling, 2 high level, 3 low level. By default line n uses code n mod 4.
- R9: The vector register returns the number of the lowest-numbered pending line.
- R10: `irq_out` is high exactly when master-enable bit 0 is 1 and some pending bit is set. Both master-enable bits read back.
- R11: An edge detected in the same cycle as the acknowledge of its line leaves the status bit set.
- R12: Status bits latch whatever their enable; disabling a line removes it only from pending, vector and output.
- R13: The registered input copy is loaded during reset, so a line already high or low when reset ends raises no edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IRQ | Interrupt request lines |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq_out | output | 1 | Interrupt to processor |

## Verification
The hardest situations to reach are the races between software and the request lines. The first is an edge that arrives in the very clock where its line is acknowledged. The second is a level line that is acknowledged while it is still held active. The stimulus drives the request change in the same half-cycle as the acknowledge write. It then reads status back at once, in the negedge right after the write's edge, and again one clock later. This exposes both the one-cycle gap on level lines and the kept edge.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NUM_IRQ = 32,
  parameter logic [2*NUM_IRQ-1:0] SENSE = {(NUM_IRQ/4){8'hE4}}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [2:0]         bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_out
);
  localparam int IDXW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam logic [2:0] A_STAT = 3'd0, A_PEND = 3'd1, A_EN = 3'd2, A_ACK = 3'd3,
                         A_SET = 3'd4, A_CLR = 3'd5, A_VEC = 3'd6, A_MST = 3'd7;

  logic [NUM_IRQ-1:0] status_q, enable_q, in_q, pending;
  logic [NUM_IRQ-1:0] edge_hit, lvl_hit, ack_m, wdata_n;
  logic [1:0]         master_q;
  logic [IDXW-1:0]    vec_idx;
  logic               vec_hit;
  logic [31:0]        vec_word;

  assign wdata_n = bus_wdata[NUM_IRQ-1:0];
  assign ack_m   = (bus_wr && bus_addr == A_ACK) ? wdata_n : '0;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_sense
    localparam logic [1:0] S = SENSE[2*g +: 2];
    if (S == 2'd0) begin : g_rise
      assign edge_hit[g] = irq_in[g] & ~in_q[g];
      assign lvl_hit[g]  = 1'b0;
    end else if (S == 2'd1) begin : g_fall
      assign edge_hit[g] = ~irq_in[g] & in_q[g];
      assign lvl_hit[g]  = 1'b0;
    end else if (S == 2'd2) begin : g_high
      assign edge_hit[g] = 1'b0;
      assign lvl_hit[g]  = irq_in[g];
    end else begin : g_low
      assign edge_hit[g] = 1'b0;
      assign lvl_hit[g]  = ~irq_in[g];
    end
  end

  always_ff @(posedge clk) begin
    in_q <= irq_in;
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      master_q <= '0;
    end else begin
      status_q <= (status_q & ~ack_m) | edge_hit | (lvl_hit & ~ack_m);
      if (bus_wr) begin
        case (bus_addr)
          A_EN:    enable_q <= wdata_n;
          A_SET:   enable_q <= enable_q | wdata_n;
          A_CLR:   enable_q <= enable_q & ~wdata_n;
          A_MST:   master_q <= bus_wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  assign pending = status_q & enable_q;
  assign irq_out = master_q[0] & (|pending);

  always_comb begin
    vec_hit = 1'b0;
    vec_idx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (pending[i]) begin
        vec_hit = 1'b1;
        vec_idx = IDXW'(i);
      end
    end
  end

  assign vec_word = vec_hit ? 32'(vec_idx) : 32'hFFFF_FFFF;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_STAT:  bus_rdata = 32'(status_q);
        A_PEND:  bus_rdata = 32'(pending);
        A_EN:    bus_rdata = 32'(enable_q);
        A_VEC:   bus_rdata = vec_word;
        A_MST:   bus_rdata = {30'd0, master_q};
        default: bus_rdata = '0;
      endcase
    end
  end

  a_r3_set_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SET) |=> ((enable_q & $past(wdata_n)) == $past(wdata_n)));

  a_r3_clr_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CLR) |=> ((enable_q & $past(wdata_n)) == '0));

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ACK) |=> ((status_q & $past(wdata_n & ~edge_hit)) == '0));

  a_r7_level_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (|(lvl_hit & ~ack_m)) |=> ((status_q & $past(lvl_hit & ~ack_m)) == $past(lvl_hit & ~ack_m)));

  a_r11_edge_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((status_q & $past(edge_hit)) == $past(edge_hit)));

  a_r9_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    vec_hit |-> (pending[vec_idx] && ((pending & ((NUM_IRQ'(1) << vec_idx) - NUM_IRQ'(1))) == '0)));
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  localparam logic [31:0] IDLE = 32'hAAAA_AAAA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] irq_in = IDLE;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // {is_write, addr, data}; read entries carry the expected value
  localparam int NT = 12;
  localparam logic [35:0] TBL [NT] = '{
    {1'b1, 3'd2, 32'h0000_00F0}, {1'b0, 3'd2, 32'h0000_00F0},
    {1'b1, 3'd4, 32'h0000_0003}, {1'b0, 3'd2, 32'h0000_00F3},
    {1'b1, 3'd5, 32'h0000_0030}, {1'b0, 3'd2, 32'h0000_00C3},
    {1'b1, 3'd7, 32'h0000_0003}, {1'b0, 3'd7, 32'h0000_0003},
    {1'b1, 3'd0, 32'hFFFF_FFFF}, {1'b0, 3'd0, 32'h0000_0000},
    {1'b1, 3'd6, 32'h0000_0000}, {1'b0, 3'd6, 32'hFFFF_FFFF}
  };

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_now(logic [2:0] a, logic [31:0] exp, string tag);
    bus_rd = 1'b1; bus_addr = a;
    #0.5;
    chk(tag, bus_rdata, exp);
    bus_rd = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    rd_now(a, exp, tag);
  endtask

  task automatic drive(logic [31:0] v);
    @(negedge clk);
    irq_in = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd0, 32'h0, "R1 status after reset (R13 idle-high lines)");
    rd(3'd2, 32'h0, "R1 enable after reset");
    rd(3'd7, 32'h0, "R1 master after reset");
    rd(3'd6, 32'hFFFF_FFFF, "R1 vector none");
    chk("R1 irq_out low", {31'd0, irq_out}, 32'h0);
    bus_addr = 3'd2;
    #0.5 chk("R2 rdata zero without strobe", bus_rdata, 32'h0);

    for (int i = 0; i < NT; i++) begin
      if (TBL[i][35]) wr(TBL[i][34:32], TBL[i][31:0]);
      else rd(TBL[i][34:32], TBL[i][31:0], "R3/R5 table entry");
    end
    rd(3'd3, 32'h0, "R2 ack reads zero");
    rd(3'd4, 32'h0, "R2 set-enable reads zero");

    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd7, 32'h1);
    rd(3'd7, 32'h1, "R10 master readback");

    // rising line 0
    drive(IDLE | 32'h1);
    rd(3'd0, 32'h1, "R6 rising edge latched");
    rd(3'd6, 32'h0, "R9 vector line 0");
    chk("R10 irq_out on", {31'd0, irq_out}, 32'h1);
    wr(3'd3, 32'h1);
    rd(3'd0, 32'h0, "R6 held edge line not re-set");
    chk("R10 irq_out off", {31'd0, irq_out}, 32'h0);
    drive(IDLE);
    rd(3'd0, 32'h0, "R6 rising line ignores fall");

    // falling line 1
    drive(IDLE & ~32'h2);
    rd(3'd1, 32'h2, "R6 falling edge pending");
    rd(3'd6, 32'h1, "R9 vector line 1");
    wr(3'd3, 32'h2);
    drive(IDLE);
    rd(3'd0, 32'h0, "R6 falling line ignores rise");

    // level-high line 2: ack while active
    drive(IDLE | 32'h4);
    rd(3'd0, 32'h4, "R7 level high latched");
    wr(3'd3, 32'h4);
    rd_now(3'd0, 32'h0, "R7 cleared in ack cycle");
    rd(3'd0, 32'h4, "R7 re-set next clock");
    drive(IDLE);
    wr(3'd3, 32'h4);
    rd(3'd0, 32'h0, "R7 released level acked");

    // priority, enable gating, master
    drive(IDLE & ~32'h28);
    rd(3'd0, 32'h28, "R8 low level and falling latched");
    rd(3'd6, 32'h3, "R9 lowest pending wins");
    wr(3'd5, 32'h8);
    rd(3'd6, 32'h5, "R9 next line after disable");
    rd(3'd0, 32'h28, "R12 status kept while disabled");
    rd(3'd1, 32'h20, "R5 pending masked");
    wr(3'd1, 32'h0);
    rd(3'd1, 32'h20, "R5 pending write ignored");
    wr(3'd7, 32'h0);
    chk("R10 master off gates output", {31'd0, irq_out}, 32'h0);
    wr(3'd7, 32'h1);
    chk("R10 master on", {31'd0, irq_out}, 32'h1);
    drive(IDLE);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd0, 32'h0, "R4 ack all");
    rd(3'd6, 32'hFFFF_FFFF, "R9 vector none after ack");

    // edge arriving with its own ack
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h10;
    irq_in = IDLE | 32'h10;
    @(negedge clk);
    bus_wr = 1'b0;
    rd_now(3'd0, 32'h10, "R11 edge kept against ack");
    wr(3'd3, 32'h10);
    rd(3'd0, 32'h0, "R4 ack single line");

    // reset with a rising line already high
    @(negedge clk);
    rst_n = 1'b0;
    irq_in = IDLE | 32'h1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rd(3'd0, 32'h0, "R13 no edge at reset release");
    rd(3'd2, 32'h0, "R1 enable cleared by reset");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule